// File: doc/BRIEF.md
# Video Memory Host Access Port

This block is the processor-facing side of a video display controller. A host reaches a 16 KB video memory one byte at a time through two byte-wide ports: a control port, through which a two-byte address is loaded, and a data port, through which bytes are read or written. A single address counter serves both directions and advances after every completed memory access. When a read address is loaded, the block fetches the addressed byte into a read-ahead latch at once. A later data-port read then returns the latched byte and fetches the next one.

Writes are held in a one-byte buffer. The block issues every memory access as a request to an external slot arbiter and holds the request until a grant arrives. While a request is outstanding the block raises `busy`. The host is expected to wait for `busy` to fall, and any host access made while `busy` is high is dropped.

Top module: `vram_host_port`

## Requirements
- R1: After reset `busy` and `mem_req` are low and `cpu_rdata` is 0x00.
- R2: Control-port writes (`cpu_sel`=1) alternate between a low byte and a high byte, starting with the low byte. The second write completes the load with address = {high[5:0], low[7:0]}. Bit 7 of the high byte has no effect.
- R3: If bit 6 of the high byte is 0 (read mode), a read request (`mem_we`=0) at the loaded address is raised in the cycle after the second control write.
- R4: If bit 6 of the high byte is 1 (write mode), loading the address raises no request. A data-port write (`cpu_sel`=0) then raises a request with `mem_we`=1, `mem_addr` equal to the counter and `mem_wdata` equal to the written byte.
- R5: A request completes in a cycle with `mem_gnt`=1. A completed read stores `mem_rdata` in the read-ahead latch, which `cpu_rdata` shows from the next cycle. Every completed access, read or write, advances the shared counter by one, so a write that follows a read-mode load lands at the loaded address plus one.
- R6: A data-port read returns the current latch value on `cpu_rdata` and raises a read request at the counter.
- R7: The counter wraps from 0x3FFF to 0x0000.
- R8: Any data-port access resets the control-port byte order, so the next control write is taken as a low byte.
- R9: `busy` and `mem_req` rise in the cycle after the host access that starts a request. They stay high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, up to and including the grant cycle, and are low in the cycle after it.
- R10: Host accesses to either port made while `busy` is high change neither the counter, the byte order, the latch nor the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Port select: 1 control, 0 data |
| cpu_wr | input | 1 | Host write strobe, one cycle |
| cpu_rd | input | 1 | Host read strobe, one cycle |
| cpu_wdata | input | 8 | Host write byte |
| cpu_rdata | output | 8 | Read-ahead latch value |
| busy | output | 1 | A memory request is outstanding |
| mem_req | output | 1 | Memory access request to the slot arbiter |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 14 | Memory byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_gnt | input | 1 | Slot grant; completes the request this cycle |
| mem_rdata | input | 8 | Read byte, valid in the grant cycle |

## Verification
The bench builds the block with its default parameters: a 14-bit address and 8-bit data. With these values the wrap at 0x3FFF and the ignored top bit of the high byte can be reached directly by directed loads. Random grant delays of zero to three cycles place host accesses inside an outstanding request, which exercises the rule that accesses made while busy are dropped. Mixed random loads, reads and writes are checked against a reference memory in the bench, which also confirms the read-then-write offset of one.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/vrp_addr_seq.sv
module vrp_addr_seq #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              data_acc,
    input  logic [DATA_W-1:0] wdata,
    output logic              load_vld,
    output logic              load_rd,
    output logic [ADDR_W-1:0] load_addr
);
    typedef struct packed {
        logic              second;
        logic [DATA_W-1:0] low;
    } seq_t;

    seq_t seq_d, seq_q;

    logic unused_top;
    assign unused_top = ^wdata[DATA_W-1:HI_W+1];

    always_comb begin
        seq_d     = seq_q;
        load_vld  = 1'b0;
        load_rd   = ~wdata[HI_W];
        load_addr = {wdata[HI_W-1:0], seq_q.low};
        if (data_acc) begin
            seq_d.second = 1'b0;
        end else if (ctl_wr) begin
            if (!seq_q.second) begin
                seq_d.low    = wdata;
                seq_d.second = 1'b1;
            end else begin
                seq_d.second = 1'b0;
                load_vld     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end
endmodule

// File: rtl/vrp_addr_ctr.sv
module vrp_addr_ctr #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load) begin
            addr_d = load_addr;
        end else if (inc) begin
            addr_d = addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/vrp_req_ctl.sv
module vrp_req_ctl
    import vrp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              gnt,
    input  logic [DATA_W-1:0] rdata,
    output logic              pend,
    output logic              we,
    output logic [DATA_W-1:0] wbuf,
    output logic [DATA_W-1:0] latch,
    output logic              done
);
    typedef struct packed {
        acc_kind_e         kind;
        logic [DATA_W-1:0] wbuf;
        logic [DATA_W-1:0] latch;
    } req_t;

    req_t req_d, req_q;

    always_comb begin
        req_d = req_q;
        done  = 1'b0;
        if (req_q.kind != ACC_IDLE) begin
            if (gnt) begin
                done       = 1'b1;
                req_d.kind = ACC_IDLE;
                if (req_q.kind == ACC_READ) begin
                    req_d.latch = rdata;
                end
            end
        end else if (start_wr) begin
            req_d.kind = ACC_WRITE;
            req_d.wbuf = wdata;
        end else if (start_rd) begin
            req_d.kind = ACC_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '{kind: ACC_IDLE, wbuf: '0, latch: '0};
        end else begin
            req_q <= req_d;
        end
    end

    assign pend  = (req_q.kind != ACC_IDLE);
    assign we    = (req_q.kind == ACC_WRITE);
    assign wbuf  = req_q.wbuf;
    assign latch = req_q.latch;
endmodule

// File: rtl/vram_host_port.sv
module vram_host_port #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              pend;
    logic              accept;
    logic              ctl_wr;
    logic              dat_wr;
    logic              dat_rd;
    logic              load_vld;
    logic              load_rd;
    logic [ADDR_W-1:0] load_addr;
    logic [ADDR_W-1:0] addr_q;
    logic              done;

    assign accept = ~pend;
    assign ctl_wr = accept & cpu_wr & cpu_sel;
    assign dat_wr = accept & cpu_wr & ~cpu_sel;
    assign dat_rd = accept & cpu_rd & ~cpu_wr & ~cpu_sel;

    vrp_addr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .data_acc  (dat_wr | dat_rd),
        .wdata     (cpu_wdata),
        .load_vld  (load_vld),
        .load_rd   (load_rd),
        .load_addr (load_addr)
    );

    vrp_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_vld),
        .load_addr (load_addr),
        .inc       (done),
        .addr      (addr_q)
    );

    vrp_req_ctl #(.DATA_W(DATA_W)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_rd (dat_rd | (load_vld & load_rd)),
        .start_wr (dat_wr),
        .wdata    (cpu_wdata),
        .gnt      (mem_gnt),
        .rdata    (mem_rdata),
        .pend     (pend),
        .we       (mem_we),
        .wbuf     (mem_wdata),
        .latch    (cpu_rdata),
        .done     (done)
    );

    assign busy     = pend;
    assign mem_req  = pend;
    assign mem_addr = addr_q;
endmodule

// File: rtl/vrp_checker.sv
module vrp_checker #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_gnt,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [ADDR_W-1:0] ctr
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9

    AST_CTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> (ctr == $past(mem_addr) + 1'b1)); // R5 R7

    AST_READ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && !mem_we) |=> (cpu_rdata == $past(mem_rdata))); // R5

    AST_WRITE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && mem_we) |-> (mem_wdata == $past(cpu_wdata) && $past(cpu_wr))); // R4

    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_gnt) |=> ($stable(ctr) && $stable(cpu_rdata))); // R10

    AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !busy); // R9
endmodule

bind vram_host_port vrp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .mem_rdata (mem_rdata),
    .ctr       (addr_q)
);

// File: tb/tb_vram_host_port.sv
module tb_vram_host_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        busy;
    logic        mem_req;
    logic        mem_we;
    logic [13:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [7:0]  mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0]  mem [int];
    logic [13:0] exp_ctr = '0;
    logic [7:0]  exp_latch = '0;
    logic        exp_second = 1'b0;
    logic [7:0]  exp_low = '0;

    always #5 clk = ~clk;

    vram_host_port dut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mem_get(logic [13:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ 8'h5A ^ {2'b00, a[13:8]};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    task automatic strobe(bit sel, bit wr, bit rd, logic [7:0] d);
        @(negedge clk);
        cpu_sel = sel; cpu_wr = wr; cpu_rd = rd; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
    endtask

    // Entered at the negedge after the starting strobe. Grants after dly cycles.
    task automatic serve(int dly, bit inj, bit exp_we, logic [13:0] exp_a,
                         logic [7:0] exp_wd, output logic [7:0] rd);
        chk(busy == 1'b1 && mem_req == 1'b1, "R9", "busy after start", int'(busy), 1);
        for (int i = 0; i < dly; i++) begin
            if (inj && i == 0) begin
                cpu_sel = 1'($urandom_range(0, 1));
                cpu_wr = 1'b1;
                cpu_wdata = 8'($urandom);
            end
            @(negedge clk);
            cpu_wr = 1'b0;
            chk(busy == 1'b1, "R9", "busy while waiting", int'(busy), 1);
        end
        chk(mem_addr == exp_a, exp_we ? "R4" : "R6", "request address", int'(mem_addr), int'(exp_a));
        chk(mem_we == exp_we, exp_we ? "R4" : "R3", "request direction", int'(mem_we), int'(exp_we));
        if (exp_we) chk(mem_wdata == exp_wd, "R4", "write byte", int'(mem_wdata), int'(exp_wd));
        rd = mem_get(mem_addr);
        mem_rdata = rd;
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        chk(busy == 1'b0 && mem_req == 1'b0, "R9", "busy after grant", int'(busy), 0);
    endtask

    task automatic ctrl_wr(logic [7:0] b, int dly, bit inj);
        logic [7:0] rd;
        logic [13:0] a;
        if (!exp_second) begin
            exp_low = b; exp_second = 1'b1;
            strobe(1'b1, 1'b1, 1'b0, b);
            chk(busy == 1'b0, "R2", "no request on first byte", int'(busy), 0);
        end else begin
            exp_second = 1'b0;
            a = {b[5:0], exp_low};
            strobe(1'b1, 1'b1, 1'b0, b);
            if (!b[6]) begin
                serve(dly, inj, 1'b0, a, 8'h00, rd);
                exp_latch = rd;
                exp_ctr = a + 14'd1;
                chk(cpu_rdata == exp_latch, "R5", "prefetch latch", int'(cpu_rdata), int'(exp_latch));
            end else begin
                chk(busy == 1'b0, "R4", "no request on write load", int'(busy), 0);
                exp_ctr = a;
            end
        end
    endtask

    task automatic load(logic [13:0] a, bit wmode, bit top, int dly, bit inj);
        ctrl_wr(a[7:0], 0, 1'b0);
        ctrl_wr({top, wmode, a[13:8]}, dly, inj);
    endtask

    task automatic data_wr(logic [7:0] b, int dly, bit inj);
        logic [7:0] rd;
        exp_second = 1'b0;
        strobe(1'b0, 1'b1, 1'b0, b);
        serve(dly, inj, 1'b1, exp_ctr, b, rd);
        exp_ctr = exp_ctr + 14'd1;
    endtask

    task automatic data_rd(int dly, bit inj);
        logic [7:0] rd;
        chk(cpu_rdata == exp_latch, "R6", "data read value", int'(cpu_rdata), int'(exp_latch));
        exp_second = 1'b0;
        strobe(1'b0, 1'b0, 1'b1, 8'h00);
        serve(dly, inj, 1'b0, exp_ctr, 8'h00, rd);
        exp_latch = rd;
        exp_ctr = exp_ctr + 14'd1;
        chk(cpu_rdata == exp_latch, "R5", "next prefetch", int'(cpu_rdata), int'(exp_latch));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy at reset", int'(busy), 0);
        chk(mem_req == 1'b0, "R1", "mem_req at reset", int'(mem_req), 0);
        chk(cpu_rdata == 8'h00, "R1", "latch at reset", int'(cpu_rdata), 0);

        // R2 R4: write-mode load and two writes
        load(14'h1234, 1'b1, 1'b0, 0, 1'b0);
        data_wr(8'hA5, 0, 1'b0);
        data_wr(8'h5B, 2, 1'b0);
        // R3 R6 R5: read back with prefetch
        load(14'h1234, 1'b0, 1'b0, 1, 1'b0);
        chk(cpu_rdata == 8'hA5, "R3", "prefetch of written byte", int'(cpu_rdata), 8'hA5);
        data_rd(0, 1'b0);
        chk(cpu_rdata == 8'h5B, "R6", "second byte prefetched", int'(cpu_rdata), 8'h5B);
        // R5 shared counter: write after read-mode load lands at +1
        load(14'h0100, 1'b0, 1'b0, 0, 1'b0);
        data_wr(8'h77, 0, 1'b0);
        chk(mem_get(14'h0101) == 8'h77, "R5", "write at loaded+1", int'(mem_get(14'h0101)), 8'h77);
        // R7 wrap, with bit 7 of high byte set (R2)
        load(14'h3FFF, 1'b1, 1'b1, 0, 1'b0);
        data_wr(8'hC3, 0, 1'b0);
        data_wr(8'h3C, 0, 1'b0);
        chk(mem_get(14'h0000) == 8'h3C, "R7", "wrapped write", int'(mem_get(14'h0000)), 8'h3C);
        // R8: a data access resets byte order
        ctrl_wr(8'h99, 0, 1'b0);
        data_rd(0, 1'b0);
        load(14'h0200, 1'b1, 1'b0, 0, 1'b0);
        data_wr(8'hE1, 1, 1'b0);
        chk(mem_get(14'h0200) == 8'hE1, "R8", "fresh load after data access", int'(mem_get(14'h0200)), 8'hE1);
        // R10: host accesses while busy are dropped
        data_wr(8'h42, 3, 1'b1);
        data_rd(2, 1'b1);
        data_wr(8'h43, 1, 1'b1);
        chk(mem_get(14'h0203) == 8'h43, "R10", "ignored accesses left counter", int'(mem_get(14'h0203)), 8'h43);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            int op;
            int dly;
            bit inj;
            op = $urandom_range(0, 3);
            dly = $urandom_range(0, 3);
            inj = (dly > 0) && ($urandom_range(0, 3) == 0);
            case (op)
                0: load(14'($urandom), 1'b0, 1'($urandom), dly, inj);
                1: load(14'($urandom), 1'b1, 1'($urandom), dly, inj);
                2: data_wr(8'($urandom), dly, inj);
                default: data_rd(dly, inj);
            endcase
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule